// File: doc/BRIEF.md
# Shared Global Counter Command Port

This block holds one free-running counter, twice the width of a data word, that several processor cores share as a common time base. Each core has its own command input and its own readback register. A core writes an 8-bit command code to ask for either the lower or the upper word of the counter. The selected word is captured into that core's readback register and stays there until the core sends its next command.

Every core has its own decoder and its own capture register. Commands from any number of cores in the same clock cycle are therefore served side by side, with no arbitration and no shared lock. A code that is neither of the two read codes makes the readback read as zero.

A constant build-configuration word reports whether the counter is implemented. When the counter is left out at build time, reads of either word return zero.

Top module: `gcc_hub`

## Requirements
- R1: While `rst` is high, every readback register reads zero. The counter is cleared, so a read issued on the first clock edge after reset is released returns zero.
- R2: After reset, the counter advances by exactly one on every clock edge and wraps from all ones to zero.
- R3: Code 0x42 on a core, with its write strobe high at a clock edge, loads that core's readback with bits [WORD_W-1:0] of the counter as it stood just before that edge. The value is visible after the edge.
- R4: Code 0x43, captured under the same timing as R3, loads the readback with bits [2*WORD_W-1:WORD_W] of the counter.
- R5: Any code other than 0x42 and 0x43, when written, loads zero into that core's readback.
- R6: While a core's write strobe is low, its readback register keeps its value, whatever appears on its code input.
- R7: Commands from several cores at the same edge are decoded independently. Each readback reflects the same counter value, selected by that core's own code.
- R8: `build_cfg` bit 0 is 1 when the counter is implemented (HAS_GCNT=1), and all other bits are 0.
- R9: When the lower word wraps from all ones to zero, the upper word read at that same count shows the carry, incremented by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | NUM_CORES | Per-core command write strobe |
| cmd_code | input | NUM_CORES*8 | Per-core command code, core i in bits [8*i+7:8*i] |
| rdback | output | NUM_CORES*WORD_W | Per-core readback register, core i in bits [WORD_W*i +: WORD_W] |
| build_cfg | output | WORD_W | Read-only build configuration; bit 0 means the counter is present |

## Verification
Two things can happen in the same cycle: the counter advances, and one or more cores capture a word of it. This can also coincide with the carry from the lower word into the upper one. The bench drives all cores at once on every cycle, across a small 8-bit-word build, for more than a full wrap of the 16-bit counter. One core reads the lower word, one reads the upper word, and a third rotates through lower-word reads, idle cycles and every unknown code. Each readback is compared with the counter value the bench computes from the number of edges since reset, taken at the edge the command was written. Equal lower-word results from two cores in one cycle, and correct upper words at each wrap, show that capture sees the pre-increment value with no interference between cores.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int unsigned GCC_CMD_W = 8;
  localparam logic [GCC_CMD_W-1:0] GCC_OP_RD_LO = 8'h42;
  localparam logic [GCC_CMD_W-1:0] GCC_OP_RD_HI = 8'h43;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } gcc_sel_e;

  function automatic gcc_sel_e gcc_decode(input logic [GCC_CMD_W-1:0] code);
    case (code)
      GCC_OP_RD_LO: return SEL_LO;
      GCC_OP_RD_HI: return SEL_HI;
      default:      return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gcc_counter.sv
module gcc_counter #(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HAS_GCNT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q
);
  generate
    if (HAS_GCNT) begin : g_cnt
      logic [CNT_W-1:0] cnt_r;
      always_ff @(posedge clk) begin
        if (rst) cnt_r <= '0;
        else     cnt_r <= cnt_r + {{(CNT_W-1){1'b0}}, 1'b1};
      end
      assign cnt_q = cnt_r;
    end else begin : g_none
      assign cnt_q = '0;
    end
  endgenerate
endmodule

// File: rtl/gcc_core_port.sv
module gcc_core_port
  import gcc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [GCC_CMD_W-1:0] code,
  input  logic [CNT_W-1:0]     cnt,
  output logic [WORD_W-1:0]    rd_q
);
  gcc_sel_e         sel;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    sel = gcc_decode(code);
    case (sel)
      SEL_LO:  word_d = cnt[WORD_W-1:0];
      SEL_HI:  word_d = cnt[CNT_W-1:WORD_W];
      default: word_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (wr) rd_q <= word_d;
  end
endmodule

// File: rtl/gcc_hub.sv
module gcc_hub
  import gcc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned WORD_W    = 32,
  parameter bit          HAS_GCNT  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CORES-1:0]          cmd_wr,
  input  logic [NUM_CORES*GCC_CMD_W-1:0] cmd_code,
  output logic [NUM_CORES*WORD_W-1:0]   rdback,
  output logic [WORD_W-1:0]             build_cfg
);
  localparam int unsigned CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] cnt_q;

  gcc_counter #(.CNT_W(CNT_W), .HAS_GCNT(HAS_GCNT)) u_cnt (
    .clk(clk), .rst(rst), .cnt_q(cnt_q)
  );

  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      gcc_core_port #(.WORD_W(WORD_W)) u_port (
        .clk (clk),
        .rst (rst),
        .wr  (cmd_wr[i]),
        .code(cmd_code[i*GCC_CMD_W +: GCC_CMD_W]),
        .cnt (cnt_q),
        .rd_q(rdback[i*WORD_W +: WORD_W])
      );
    end
  endgenerate

  assign build_cfg = {{(WORD_W-1){1'b0}}, HAS_GCNT};
endmodule

// File: rtl/gcc_hub_chk.sv
module gcc_hub_chk
  import gcc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned WORD_W    = 32,
  parameter bit          HAS_GCNT  = 1'b1
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_CORES-1:0]           cmd_wr,
  input logic [NUM_CORES*GCC_CMD_W-1:0] cmd_code,
  input logic [NUM_CORES*WORD_W-1:0]    rdback,
  input logic [2*WORD_W-1:0]            cnt_q
);
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (rdback == '0 && cnt_q == '0));

  generate
    if (HAS_GCNT) begin : g_cnt_chk
      a_r2_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);
    end
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core_chk
      a_r3_lo_word: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr[i] && cmd_code[i*GCC_CMD_W +: GCC_CMD_W] == GCC_OP_RD_LO)
        |=> rdback[i*WORD_W +: WORD_W] == $past(cnt_q[WORD_W-1:0]));
      a_r4_hi_word: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr[i] && cmd_code[i*GCC_CMD_W +: GCC_CMD_W] == GCC_OP_RD_HI)
        |=> rdback[i*WORD_W +: WORD_W] == $past(cnt_q[2*WORD_W-1:WORD_W]));
      a_r5_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr[i] && cmd_code[i*GCC_CMD_W +: GCC_CMD_W] != GCC_OP_RD_LO
                   && cmd_code[i*GCC_CMD_W +: GCC_CMD_W] != GCC_OP_RD_HI)
        |=> rdback[i*WORD_W +: WORD_W] == '0);
      a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr[i] |=> $stable(rdback[i*WORD_W +: WORD_W]));
    end
  endgenerate
endmodule

bind gcc_hub gcc_hub_chk #(.NUM_CORES(NUM_CORES), .WORD_W(WORD_W), .HAS_GCNT(HAS_GCNT)) u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
  .rdback(rdback), .cnt_q(cnt_q)
);

// File: tb/sim_gcc_hub.sv
module sim_gcc_hub;
  localparam int unsigned NC = 3;
  localparam int unsigned W  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cmd_wr = '0;
  logic [NC*8-1:0] cmd_code = '0;
  logic [NC*W-1:0] rdback;
  logic [W-1:0]    build_cfg;

  int nchk = 0;
  int nerr = 0;
  logic [2*W-1:0] mcnt = '0;

  gcc_hub #(.NUM_CORES(NC), .WORD_W(W), .HAS_GCNT(1'b1)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .rdback(rdback), .build_cfg(build_cfg)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) mcnt <= '0;
    else     mcnt <= mcnt + 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rb(input int c);
    return rdback[c*W +: W];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [W-1:0] e0, e1, e2;
    logic [7:0]   ucode;
    logic [2*W-1:0] snap;
    ucode = 8'h00;
    e2 = '0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R1 readback in reset", rb(c), 0);
    chk("R8 build_cfg", build_cfg, 1);

    // release reset and start the sweep at the same falling edge
    rst = 1'b0;
    for (int cyc = 0; cyc < 66000; cyc++) begin
      snap = mcnt;
      cmd_wr = '1;
      cmd_code[0*8 +: 8] = 8'h42;
      cmd_code[1*8 +: 8] = 8'h43;
      e0 = snap[W-1:0];
      e1 = snap[2*W-1:W];
      case (cyc % 4)
        0: begin cmd_code[2*8 +: 8] = 8'h42; e2 = snap[W-1:0]; end
        2: begin
             while (ucode == 8'h42 || ucode == 8'h43) ucode++;
             cmd_code[2*8 +: 8] = ucode;
             ucode++;
             e2 = '0;
           end
        default: begin cmd_wr[2] = 1'b0; cmd_code[2*8 +: 8] = 8'h42; end
      endcase
      @(negedge clk);
      if (cyc == 0) chk("R1 first read after reset", rb(0), 0);
      chk("R3 low word core0", rb(0), e0);
      chk("R4 high word core1", rb(1), e1);
      if (cyc % 4 == 0) chk("R7 same-cycle low reads agree", rb(2), rb(0));
      else if (cyc % 4 == 2) chk("R5 unknown code reads zero", rb(2), 0);
      else chk("R6 readback holds while idle", rb(2), e2);
      if (snap[W-1:0] == '0 && snap != '0) chk("R9 carry into high word", rb(1), e1);
    end

    // counter wrapped past all ones: check low and high equal model
    chk("R2 counter wrapped", {16'h0, mcnt}, 32'(66000 % 65536));

    // reset in the middle of traffic
    cmd_wr = '1;
    for (int c = 0; c < NC; c++) cmd_code[c*8 +: 8] = 8'h42;
    rst = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R1 reset overrides command", rb(c), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 counter restarts from zero", rb(0), 0);
    cmd_wr = '0;
    repeat (5) @(negedge clk);
    chk("R6 hold after idle", rb(1), 0);
    cmd_wr[1] = 1'b1;
    snap = mcnt;
    @(negedge clk);
    chk("R3 low after restart", rb(1), {24'h0, snap[W-1:0]});
    cmd_wr = '0;

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule